// File: doc/BRIEF.md
# Scattered Bit-Field Register Writer

This block spreads one numeric value over several partial fields of an 8-bit indexed register file. A caller gives it the value and the base address of a descriptor list. Each descriptor names one register and a contiguous bit range inside it. The block walks the list in address order. For each descriptor it reads the register, overwrites only the named bit range with the next unused bits of the value, and writes the byte back. It stops at a descriptor that carries a reserved end index. Timing counters whose widths do not fit one byte can then be set with a single request instead of a chain of masked accesses.

The same walk can also run in a query mode, which touches no register. In that mode the block only adds up the field widths. After either kind of run, the block reports the summed width and the number of distinct values that the fields can hold together.

Top module: `sfw_writer`

## Requirements
- R1: A descriptor is 14 bits: bits [13:6] hold the register index, bits [5:3] the top bit position, and bits [2:0] the bottom bit position. The list ends at the first descriptor whose index is 8'hFF. The list is read at `desc_addr`, which starts at `start_base` and increases by one per descriptor.
- R2: Value bits are used least significant first. Inside one descriptor, they fill positions from the bottom bit up to the top bit. The next descriptor in list order continues with the bits that remain, and one write is issued per descriptor in that order.
- R3: Every register write keeps, outside the descriptor's bit range, the bits that the read of that register returned. A register that appears twice in a list sees the result of the earlier write.
- R4: A register read is issued and acknowledged before the write to the same register. Only one access is pending at a time. `reg_req`, `reg_idx` and `reg_we` stay stable until `reg_ack`.
- R5: `done` is high for exactly one cycle, two cycles after the clock edge that accepts the last write acknowledge. For an empty list, `done` is high in the second cycle after the start is accepted.
- R6: Value bits above the summed field width never reach any register.
- R7: With `start_query` high, the block reads the list but issues no register access. It reports `total_width` as the sum of (top - bottom + 1) over the descriptors. It reports `value_space` as 2 to the power `total_width`, saturated to all ones when `total_width` exceeds 32.
- R8: A write run updates `total_width` and `value_space` in the same way as a query run.
- R9: `busy` rises in the cycle after a start is accepted and stays high until after `done`. A start request seen while `busy` is high is ignored.
- R10: After reset, `busy`, `done` and `reg_req` are low, `total_width` is 0 and `value_space` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Start a run; accepted only while idle |
| start_query | input | 1 | With start: only sum the widths, no register access |
| start_value | input | 32 | Value to distribute |
| start_base | input | 6 | Address of the first descriptor |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| desc_addr | output | 6 | Descriptor list address |
| desc_entry | input | 14 | Descriptor at `desc_addr`, combinational |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_idx | output | 8 | Register index |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid with `reg_ack` |
| reg_ack | input | 1 | Access completes at this clock edge |
| total_width | output | 10 | Summed field width of the last run |
| value_space | output | 33 | Number of values the fields can represent |

## Verification
The checks assume that every descriptor has its bottom bit no higher than its top bit. They assume that the descriptor port answers in the same cycle, and that `reg_ack` appears only while `reg_req` is high. The bench's register responder acknowledges only pending requests and varies its wait from zero to two cycles. Every list the bench builds has well-ordered ranges and ends at the end index. The bench drives starts only from idle, except in the one deliberate overlap, which exercises the rule that a start during a run is ignored.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } sfw_state_e;
endpackage

// File: rtl/sfw_field_merge.sv
module sfw_field_merge #(
  parameter int REG_W = 8,
  parameter int VAL_W = 32,
  parameter int POS_W = 3
) (
  input  logic [REG_W-1:0] old_byte,
  input  logic [VAL_W-1:0] bits,
  input  logic [POS_W-1:0] lo,
  input  logic [POS_W-1:0] hi,
  output logic [REG_W-1:0] merged,
  output logic [POS_W:0]   width
);
  function automatic logic [POS_W:0] span_of(input logic [POS_W-1:0] l, input logic [POS_W-1:0] h);
    if (h >= l) return {1'b0, h} - {1'b0, l} + 1'b1;
    return '0;
  endfunction

  function automatic logic [REG_W-1:0] splice(input logic [REG_W-1:0] o, input logic [VAL_W-1:0] v,
                                              input logic [POS_W-1:0] l, input logic [POS_W-1:0] h);
    logic [REG_W-1:0] r;
    r = o;
    for (int b = 0; b < REG_W; b++) begin
      if (b >= int'(l) && b <= int'(h)) r[b] = v[b - int'(l)];
    end
    return r;
  endfunction

  always_comb begin
    width  = span_of(lo, hi);
    merged = splice(old_byte, bits, lo, hi);
  end
endmodule

// File: rtl/sfw_span.sv
module sfw_span #(
  parameter int TOT_W = 10,
  parameter int VAL_W = 32
) (
  input  logic [TOT_W-1:0] total,
  output logic [VAL_W:0]   space
);
  function automatic logic [VAL_W:0] pow2_sat(input logic [TOT_W-1:0] t);
    if (int'(t) > VAL_W) return {(VAL_W+1){1'b1}};
    return (VAL_W+1)'(1) << t;
  endfunction

  assign space = pow2_sat(total);
endmodule

// File: rtl/sfw_walker.sv
module sfw_walker
  import sfw_pkg::*;
#(
  parameter int          IDX_W   = 8,
  parameter int          POS_W   = 3,
  parameter int          REG_W   = 8,
  parameter int          VAL_W   = 32,
  parameter int          LIST_AW = 6,
  parameter int          TOT_W   = 10,
  parameter logic [7:0]  END_IDX = 8'hFF,
  localparam int         DESC_W  = IDX_W + 2*POS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               start_query,
  input  logic [VAL_W-1:0]   start_value,
  input  logic [LIST_AW-1:0] start_base,
  input  logic [DESC_W-1:0]  desc_entry,
  input  logic               reg_ack,
  input  logic [REG_W-1:0]   merged_byte,
  input  logic [POS_W:0]     field_w,
  output logic               busy,
  output logic               done,
  output logic [LIST_AW-1:0] desc_addr,
  output logic               reg_req,
  output logic               reg_we,
  output logic [IDX_W-1:0]   reg_idx,
  output logic [REG_W-1:0]   reg_wdata,
  output logic [POS_W-1:0]   field_lo,
  output logic [POS_W-1:0]   field_hi,
  output logic [VAL_W-1:0]   value_bits,
  output logic [TOT_W-1:0]   total_width,
  output logic               rd_ack_ev,
  output logic               wr_ack_ev,
  output logic               list_end_ev
);
  sfw_state_e         state_q;
  logic [LIST_AW-1:0] ptr_q;
  logic [VAL_W-1:0]   val_q;
  logic               query_q;
  logic [IDX_W-1:0]   idx_q;
  logic [POS_W-1:0]   lo_q, hi_q;
  logic [REG_W-1:0]   wbyte_q;
  logic [TOT_W-1:0]   total_q;

  logic [IDX_W-1:0]   d_idx;
  logic [POS_W-1:0]   d_lo, d_hi;
  logic               fetching;

  assign d_idx = desc_entry[DESC_W-1 -: IDX_W];
  assign d_hi  = desc_entry[2*POS_W-1 -: POS_W];
  assign d_lo  = desc_entry[POS_W-1:0];

  assign fetching    = (state_q == ST_FETCH);
  assign list_end_ev = fetching && (d_idx == IDX_W'(END_IDX));
  assign rd_ack_ev   = (state_q == ST_READ)  && reg_ack;
  assign wr_ack_ev   = (state_q == ST_WRITE) && reg_ack;

  assign field_lo    = fetching ? d_lo : lo_q;
  assign field_hi    = fetching ? d_hi : hi_q;
  assign value_bits  = val_q;
  assign desc_addr   = ptr_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign reg_req     = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign reg_we      = (state_q == ST_WRITE);
  assign reg_idx     = idx_q;
  assign reg_wdata   = wbyte_q;
  assign total_width = total_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      val_q   <= '0;
      query_q <= 1'b0;
      idx_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      wbyte_q <= '0;
      total_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            state_q <= ST_FETCH;
            ptr_q   <= start_base;
            val_q   <= start_value;
            query_q <= start_query;
            total_q <= '0;
          end
        end
        ST_FETCH: begin
          if (list_end_ev) begin
            state_q <= ST_DONE;
          end else if (query_q) begin
            total_q <= total_q + TOT_W'(field_w);
            ptr_q   <= ptr_q + 1'b1;
          end else begin
            idx_q   <= d_idx;
            lo_q    <= d_lo;
            hi_q    <= d_hi;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (reg_ack) begin
            wbyte_q <= merged_byte;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (reg_ack) begin
            val_q   <= val_q >> field_w;
            total_q <= total_q + TOT_W'(field_w);
            ptr_q   <= ptr_q + 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfw_writer.sv
module sfw_writer #(
  parameter int         VAL_W   = 32,
  parameter int         REG_W   = 8,
  parameter int         IDX_W   = 8,
  parameter int         LIST_AW = 6,
  parameter logic [7:0] END_IDX = 8'hFF,
  localparam int        POS_W   = $clog2(REG_W),
  localparam int        DESC_W  = IDX_W + 2*POS_W,
  localparam int        TOT_W   = $clog2(((1 << LIST_AW) * REG_W) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               start_query,
  input  logic [VAL_W-1:0]   start_value,
  input  logic [LIST_AW-1:0] start_base,
  output logic               busy,
  output logic               done,
  output logic [LIST_AW-1:0] desc_addr,
  input  logic [DESC_W-1:0]  desc_entry,
  output logic               reg_req,
  output logic               reg_we,
  output logic [IDX_W-1:0]   reg_idx,
  output logic [REG_W-1:0]   reg_wdata,
  input  logic [REG_W-1:0]   reg_rdata,
  input  logic               reg_ack,
  output logic [TOT_W-1:0]   total_width,
  output logic [VAL_W:0]     value_space
);
  logic [REG_W-1:0] merged_byte;
  logic [POS_W:0]   field_w;
  logic [POS_W-1:0] field_lo, field_hi;
  logic [VAL_W-1:0] value_bits;
  logic             rd_ack_ev, wr_ack_ev, list_end_ev;

  sfw_walker #(
    .IDX_W(IDX_W), .POS_W(POS_W), .REG_W(REG_W), .VAL_W(VAL_W),
    .LIST_AW(LIST_AW), .TOT_W(TOT_W), .END_IDX(END_IDX)
  ) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req), .start_query(start_query),
    .start_value(start_value), .start_base(start_base),
    .desc_entry(desc_entry), .reg_ack(reg_ack),
    .merged_byte(merged_byte), .field_w(field_w),
    .busy(busy), .done(done), .desc_addr(desc_addr),
    .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .field_lo(field_lo), .field_hi(field_hi), .value_bits(value_bits),
    .total_width(total_width),
    .rd_ack_ev(rd_ack_ev), .wr_ack_ev(wr_ack_ev), .list_end_ev(list_end_ev)
  );

  sfw_field_merge #(.REG_W(REG_W), .VAL_W(VAL_W), .POS_W(POS_W)) u_merge (
    .old_byte(reg_rdata), .bits(value_bits), .lo(field_lo), .hi(field_hi),
    .merged(merged_byte), .width(field_w)
  );

  sfw_span #(.TOT_W(TOT_W), .VAL_W(VAL_W)) u_span (
    .total(total_width), .space(value_space)
  );
endmodule

// File: rtl/sfw_checker.sv
module sfw_checker #(
  parameter int REG_W = 8,
  parameter int IDX_W = 8,
  parameter int POS_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_req,
  input logic             start_query,
  input logic             busy,
  input logic             done,
  input logic             reg_req,
  input logic             reg_we,
  input logic [IDX_W-1:0] reg_idx,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [POS_W-1:0] field_lo,
  input logic [POS_W-1:0] field_hi,
  input logic             rd_ack_ev,
  input logic             wr_ack_ev,
  input logic             list_end_ev
);
  logic             rd_seen_q;
  logic             query_q;
  logic [REG_W-1:0] keep_q;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] mask_now;

  always_comb begin
    mask_now = '0;
    for (int b = 0; b < REG_W; b++)
      if (b >= int'(field_lo) && b <= int'(field_hi)) mask_now[b] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen_q <= 1'b0;
      query_q   <= 1'b0;
      keep_q    <= '0;
      mask_q    <= '0;
    end else begin
      if (start_req && !busy) query_q <= start_query;
      if (rd_ack_ev) begin
        rd_seen_q <= 1'b1;
        keep_q    <= reg_rdata;
        mask_q    <= mask_now;
      end else if (wr_ack_ev) begin
        rd_seen_q <= 1'b0;
      end
    end
  end

  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !(rd_ack_ev || wr_ack_ev)) |=> (reg_req && $stable(reg_idx) && $stable(reg_we)));

  a_r4_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we) |-> rd_seen_q);

  a_r3_keep_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we) |-> (((reg_wdata ^ keep_q) & ~mask_q) == '0));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(list_end_ev));

  a_r7_query_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && query_q) |-> !reg_req);

  a_r9_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !busy) |=> busy);
endmodule

bind sfw_writer sfw_checker #(.REG_W(REG_W), .IDX_W(IDX_W), .POS_W(POS_W)) u_sfw_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_query(start_query),
  .busy(busy), .done(done), .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .field_lo(field_lo), .field_hi(field_hi),
  .rd_ack_ev(rd_ack_ev), .wr_ack_ev(wr_ack_ev), .list_end_ev(list_end_ev)
);

// File: tb/test_sfw_writer.sv
`timescale 1ns/1ps
module test_sfw_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic        start_query = 1'b0;
  logic [31:0] start_value = '0;
  logic [5:0]  start_base = '0;
  logic        busy, done;
  logic [5:0]  desc_addr;
  logic [13:0] desc_entry;
  logic        reg_req, reg_we;
  logic [7:0]  reg_idx, reg_wdata;
  logic [7:0]  reg_rdata = '0;
  logic        reg_ack = 1'b0;
  logic [9:0]  total_width;
  logic [32:0] value_space;

  always #4 clk = ~clk;

  logic [13:0] desc_mem [64];
  logic [7:0]  regs  [256];
  logic [7:0]  model [256];
  logic [7:0]  q_idx [$];
  logic [7:0]  q_dat [$];
  int          n_vec = 0, n_bad = 0;
  int          cyc = 0, last_wr_cyc = 0, acc_cnt = 0, wait_left = 0;
  int          exp_total;
  logic [32:0] exp_space;

  assign desc_entry = desc_mem[desc_addr];

  sfw_writer i_sfw_writer (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .start_query(start_query),
    .start_value(start_value), .start_base(start_base), .busy(busy), .done(done),
    .desc_addr(desc_addr), .desc_entry(desc_entry), .reg_req(reg_req), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .total_width(total_width), .value_space(value_space)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input logic [7:0] idx, input int lo, input int hi);
    return {idx, 3'(hi), 3'(lo)};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // register responder with varying wait, plus per-write comparison against the model queue
  always @(negedge clk) begin
    if (reg_ack) begin
      reg_ack <= 1'b0;
    end else if (reg_req) begin
      if (wait_left > 0) begin
        wait_left <= wait_left - 1;
      end else begin
        reg_ack   <= 1'b1;
        acc_cnt   <= acc_cnt + 1;
        wait_left <= (acc_cnt + 1) % 3;
        if (reg_we) begin
          last_wr_cyc <= cyc;
          if (q_idx.size() == 0) begin
            chk(1'b0, "R2 unexpected write", {56'd0, reg_idx}, 64'd0);
          end else begin
            automatic logic [7:0] ei = q_idx.pop_front();
            automatic logic [7:0] ed = q_dat.pop_front();
            chk(reg_idx == ei, "R2 write order index", {56'd0, reg_idx}, {56'd0, ei});
            chk(reg_wdata == ed, "R3 write data", {56'd0, reg_wdata}, {56'd0, ed});
          end
          regs[reg_idx] <= reg_wdata;
        end else begin
          reg_rdata <= regs[reg_idx];
        end
      end
    end
  end

  // behavioural model of one run: walks the list with integers
  task automatic build_expect(input logic [31:0] value, input int base, input bit query);
    automatic longint v = longint'(value);
    automatic int a = base;
    exp_total = 0;
    forever begin
      automatic logic [13:0] d = desc_mem[a];
      automatic int idx = int'(d[13:6]);
      automatic int hi = int'(d[5:3]);
      automatic int lo = int'(d[2:0]);
      if (idx == 255) break;
      exp_total += hi - lo + 1;
      if (!query) begin
        automatic logic [7:0] nb = model[idx];
        for (int p = lo; p <= hi; p++) begin
          nb[p] = v[0];
          v = v >> 1;
        end
        model[idx] = nb;
        q_idx.push_back(8'(idx));
        q_dat.push_back(nb);
      end
      a = (a + 1) % 64;
    end
    exp_space = (exp_total > 32) ? 33'h1_FFFF_FFFF : (33'd1 << exp_total);
  endtask

  task automatic run(input logic [31:0] value, input int base, input bit query,
                     input bit empty, input bit inject, input string tag);
    automatic int start_cyc;
    automatic int acc0;
    automatic int n;
    automatic bit got = 0;
    build_expect(value, base, query);
    acc0 = acc_cnt;
    @(negedge clk);
    start_req = 1'b1; start_value = value; start_base = 6'(base); start_query = query;
    start_cyc = cyc;
    @(negedge clk);
    start_req = 1'b0;
    if (inject) begin
      @(negedge clk);
      @(negedge clk);
      chk(busy == 1'b1, "R9 busy during run", {63'd0, busy}, 64'd1);
      start_req = 1'b1; start_value = ~value; start_base = 6'(base + 1); start_query = 1'b0;
      @(negedge clk);
      start_req = 1'b0;
    end
    n = 0;
    while (!got && n < 2000) begin
      if (done) got = 1; else begin @(negedge clk); n++; end
    end
    chk(got, {tag, " R5 done seen"}, {63'd0, got}, 64'd1);
    if (empty || query) begin
      if (empty) chk(cyc - start_cyc == 2, "R5 empty list latency", 64'(cyc - start_cyc), 64'd2);
      chk(acc_cnt == acc0, {tag, " R7 no register access"}, 64'(acc_cnt - acc0), 64'd0);
    end else begin
      chk(cyc - last_wr_cyc == 2, {tag, " R5 done after last write"}, 64'(cyc - last_wr_cyc), 64'd2);
    end
    @(negedge clk);
    chk(done == 1'b0, {tag, " R5 done one cycle"}, {63'd0, done}, 64'd0);
    chk(busy == 1'b0, {tag, " R9 idle after done"}, {63'd0, busy}, 64'd0);
    chk(q_idx.size() == 0, {tag, " R2 all writes issued"}, 64'(q_idx.size()), 64'd0);
    chk(int'(total_width) == exp_total, {tag, " R7 R8 total width"}, 64'(total_width), 64'(exp_total));
    chk(value_space == exp_space, {tag, " R7 R8 value space"}, 64'(value_space), 64'(exp_space));
    begin
      automatic int diffs = 0;
      for (int i = 0; i < 256; i++) if (regs[i] !== model[i]) diffs++;
      chk(diffs == 0, {tag, " R3 R6 register file"}, 64'(diffs), 64'd0);
    end
    q_idx.delete(); q_dat.delete();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) desc_mem[i] = mk(8'hFF, 0, 0);
    for (int i = 0; i < 256; i++) begin
      regs[i]  = 8'(i * 37 + 5);
      model[i] = 8'(i * 37 + 5);
    end
    // R1 list layout: single field, carry list, full byte + overflow, repeated register, empty, wide
    desc_mem[0]  = mk(8'h05, 2, 5);
    desc_mem[4]  = mk(8'h10, 4, 7);
    desc_mem[5]  = mk(8'h11, 0, 2);
    desc_mem[6]  = mk(8'h12, 3, 3);
    desc_mem[10] = mk(8'h20, 0, 7);
    desc_mem[11] = mk(8'h21, 6, 7);
    desc_mem[14] = mk(8'h30, 0, 1);
    desc_mem[15] = mk(8'h30, 6, 7);
    desc_mem[16] = mk(8'h30, 3, 4);
    for (int i = 0; i < 5; i++) desc_mem[24 + i] = mk(8'(8'h40 + i), 0, 7);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0,        "R10 busy after reset", {63'd0, busy}, 64'd0);
    chk(done == 1'b0,        "R10 done after reset", {63'd0, done}, 64'd0);
    chk(reg_req == 1'b0,     "R10 no request after reset", {63'd0, reg_req}, 64'd0);
    chk(total_width == 10'd0,"R10 total after reset", 64'(total_width), 64'd0);
    chk(value_space == 33'd1,"R10 space after reset", 64'(value_space), 64'd1);

    run(32'h0000_000A, 0,  1'b0, 1'b0, 1'b0, "R1 single field");
    run(32'h0000_05A5, 4,  1'b0, 1'b0, 1'b0, "R2 carry across entries");
    run(32'hFFFF_FC3A, 10, 1'b0, 1'b0, 1'b0, "R6 excess bits dropped");
    run(32'h0000_002D, 14, 1'b0, 1'b0, 1'b0, "R3 repeated register");
    run(32'h1234_5678, 20, 1'b0, 1'b1, 1'b0, "R5 empty list");
    run(32'hDEAD_BEEF, 4,  1'b1, 1'b0, 1'b0, "R7 query");
    run(32'h0,         24, 1'b1, 1'b0, 1'b0, "R7 saturated query");
    run(32'h89AB_CDEF, 24, 1'b0, 1'b0, 1'b0, "R8 wide write");
    run(32'h0000_003C, 4,  1'b0, 1'b0, 1'b1, "R9 start ignored");
    begin
      automatic int acc0 = acc_cnt;
      repeat (10) @(negedge clk);
      chk(acc_cnt == acc0 && !busy, "R9 no second run", 64'(acc_cnt - acc0), 64'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule